// File: doc/BRIEF.md
# Coherent Shadow Register Reload Controller

This block holds a bank of double-buffered control registers. Software writes go to the shadow half only. The active half, which downstream logic consumes, changes only at a master reload event that marks the start of a control period. Most registers follow one global reload-enable bit ("arm"). Software sets this bit after it has finished a batch of shadow writes, so the active side never holds a half-written set. The last `NUM_LOCAL` registers each follow their own arm bit instead.

When a reload event arrives with the global arm bit clear, every globally gated active register keeps its value. A sticky error flag is raised instead, and it drives an interrupt line when the interrupt is enabled. A small two-state machine tracks the global arm bit. Its states are `ST_OPEN` (software may still be editing; an event here is an early event) and `ST_ARMED` (the update is complete; an event here commits).

The machine has four transitions:
- `OPEN->ARMED` on an arm request.
- `ARMED->OPEN` on a reload event.
- `ARMED->ARMED` on a reload event that coincides with a new arm request.
- `OPEN->OPEN` on an early event.

Top module: `shadow_reload_ctrl`

## Requirements
- R1: After reset every active register holds `RST_VAL`, `gre_armed`, all `local_armed` bits, `err_flag` and `irq` are 0.
- R2: A shadow write never changes any active output in a cycle without a reload event that copies that register.
- R3: A reload event while `gre_armed` is 1 copies every globally gated shadow register (indices below `NUM_REGS-NUM_LOCAL`) to its active copy at that clock edge, and `gre_armed` returns to 0 at the same edge.
- R4: A reload event while `gre_armed` is 0 leaves every globally gated active register unchanged and sets `err_flag` at that edge.
- R5: `irq` is 1 exactly while `err_flag` is 1 and `err_irq_en` is 1.
- R6: `err_flag` stays set until `err_clr` is pulsed. When a clear and a new early event coincide, the flag stays 1.
- R7: A shadow write in the same cycle as a committing reload event does not reach the active copy at that event. The copy uses the earlier shadow value, and the new value appears at the next committing event.
- R8: Register `NUM_REGS-NUM_LOCAL+k` is gated by `local_set[k]` / `local_armed[k]` only. A reload event copies it when its bit is 1 and clears the bit; otherwise it is held. The global arm bit has no effect on it, and a clear local bit raises no error.
- R9: An arm request (`gre_set` or `local_set[k]`) in the same cycle as a reload event is taken after the event is evaluated. `gre_set` with an early event still sets `err_flag`, and the arm bit reads 1 afterwards.
- R10: A shadow write to an address of `NUM_REGS` or above changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Shadow write strobe |
| wr_addr | input | ADDR_W | Shadow register index |
| wr_data | input | DATA_W | Shadow write data |
| gre_set | input | 1 | Request to set the global arm bit |
| local_set | input | NUM_LOCAL | Requests to set the per-register arm bits |
| reload_evt | input | 1 | Master reload event pulse (start of control period) |
| err_clr | input | 1 | Clears the reload error flag |
| err_irq_en | input | 1 | Enables the reload error interrupt |
| active_o | output | NUM_REGS*DATA_W | Active register values, register i at bits [i*DATA_W +: DATA_W] |
| gre_armed | output | 1 | Global arm bit |
| local_armed | output | NUM_LOCAL | Per-register arm bits |
| err_flag | output | 1 | Sticky reload error flag |
| irq | output | 1 | Reload error interrupt request |

## Verification
A machine stuck in the wrong state is visible on `gre_armed` in the cycle after the fault. At the next reload event it also shows as a missing or spurious `err_flag` and a missed or unwanted change of `active_o`, both one edge later. A shadow register holding a wrong value stays hidden until a committing event copies it to `active_o`. For that reason, each scenario ends with a commit and compares the whole active bus.

// File: rtl/srr_pkg.sv
package srr_pkg;
    typedef enum logic [0:0] {
        ST_OPEN  = 1'b0,
        ST_ARMED = 1'b1
    } gre_state_t;
endpackage

// File: rtl/srr_seq.sv
module srr_seq
    import srr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gre_set,
    input  logic reload_evt,
    output logic commit_g,
    output logic early_evt,
    output logic armed
);
    gre_state_t state_q, state_d;

    // next-state logic; arm requests are taken after the event is judged
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: begin
                if (gre_set) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (reload_evt && !gre_set) state_d = ST_OPEN;
            end
            default: state_d = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        commit_g  = 1'b0;
        early_evt = 1'b0;
        armed     = 1'b0;
        unique case (state_q)
            ST_OPEN:  early_evt = reload_evt;
            ST_ARMED: begin
                commit_g = reload_evt;
                armed    = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/srr_bank.sv
module srr_bank #(
    parameter int          DATA_W  = 16,
    parameter int          ADDR_W  = 3,
    parameter int          IDX     = 0,
    parameter bit          LOCAL   = 1'b0,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit_g,
    input  logic              reload_evt,
    input  logic              arm_set,
    output logic [DATA_W-1:0] active,
    output logic              arm_q
);
    logic [DATA_W-1:0] shadow_q;
    logic              load;
    logic              hit;

    assign hit = wr_en && (wr_addr == ADDR_W'(IDX));

    always_ff @(posedge clk) begin
        if (!rst_n)   shadow_q <= RST_VAL;
        else if (hit) shadow_q <= wr_data;
    end

    generate
        if (LOCAL) begin : g_local
            logic arm_r;
            always_ff @(posedge clk) begin
                if (!rst_n)                  arm_r <= 1'b0;
                else if (arm_set)            arm_r <= 1'b1;
                else if (reload_evt && arm_r) arm_r <= 1'b0;
            end
            assign load  = reload_evt && arm_r;
            assign arm_q = arm_r;
        end else begin : g_global
            assign load  = commit_g;
            assign arm_q = 1'b0;
        end
    endgenerate

    // active copy samples the shadow value from before this edge's write
    always_ff @(posedge clk) begin
        if (!rst_n)    active <= RST_VAL;
        else if (load) active <= shadow_q;
    end
endmodule

// File: rtl/srr_err.sv
module srr_err (
    input  logic clk,
    input  logic rst_n,
    input  logic early_evt,
    input  logic err_clr,
    input  logic err_irq_en,
    output logic err_flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (!rst_n)         err_flag <= 1'b0;
        else if (early_evt) err_flag <= 1'b1;
        else if (err_clr)   err_flag <= 1'b0;
    end

    assign irq = err_flag & err_irq_en;
endmodule

// File: rtl/shadow_reload_ctrl.sv
module shadow_reload_ctrl #(
    parameter int                NUM_REGS  = 5,
    parameter int                NUM_LOCAL = 2,
    parameter int                DATA_W    = 16,
    parameter logic [DATA_W-1:0] RST_VAL   = 16'h00A5,
    parameter int                ADDR_W    = $clog2(NUM_REGS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       gre_set,
    input  logic [NUM_LOCAL-1:0]       local_set,
    input  logic                       reload_evt,
    input  logic                       err_clr,
    input  logic                       err_irq_en,
    output logic [NUM_REGS*DATA_W-1:0] active_o,
    output logic                       gre_armed,
    output logic [NUM_LOCAL-1:0]       local_armed,
    output logic                       err_flag,
    output logic                       irq
);
    localparam int NUM_GLOBAL = NUM_REGS - NUM_LOCAL;

    logic commit_g;
    logic early_evt;

    srr_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .gre_set   (gre_set),
        .reload_evt(reload_evt),
        .commit_g  (commit_g),
        .early_evt (early_evt),
        .armed     (gre_armed)
    );

    srr_err u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .early_evt (early_evt),
        .err_clr   (err_clr),
        .err_irq_en(err_irq_en),
        .err_flag  (err_flag),
        .irq       (irq)
    );

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
            if (i < NUM_GLOBAL) begin : g_gl
                logic unused_arm;
                srr_bank #(
                    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX(i),
                    .LOCAL(1'b0), .RST_VAL(RST_VAL)
                ) u_bank (
                    .clk       (clk),
                    .rst_n     (rst_n),
                    .wr_en     (wr_en),
                    .wr_addr   (wr_addr),
                    .wr_data   (wr_data),
                    .commit_g  (commit_g),
                    .reload_evt(reload_evt),
                    .arm_set   (1'b0),
                    .active    (active_o[i*DATA_W +: DATA_W]),
                    .arm_q     (unused_arm)
                );
            end else begin : g_lc
                srr_bank #(
                    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX(i),
                    .LOCAL(1'b1), .RST_VAL(RST_VAL)
                ) u_bank (
                    .clk       (clk),
                    .rst_n     (rst_n),
                    .wr_en     (wr_en),
                    .wr_addr   (wr_addr),
                    .wr_data   (wr_data),
                    .commit_g  (commit_g),
                    .reload_evt(reload_evt),
                    .arm_set   (local_set[i-NUM_GLOBAL]),
                    .active    (active_o[i*DATA_W +: DATA_W]),
                    .arm_q     (local_armed[i-NUM_GLOBAL])
                );
            end
        end
    endgenerate
endmodule

// File: rtl/srr_checker.sv
module srr_checker #(
    parameter int NUM_REGS  = 5,
    parameter int NUM_LOCAL = 2,
    parameter int DATA_W    = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       gre_set,
    input logic [NUM_LOCAL-1:0]       local_set,
    input logic                       reload_evt,
    input logic                       err_clr,
    input logic [NUM_REGS*DATA_W-1:0] active_o,
    input logic                       gre_armed,
    input logic [NUM_LOCAL-1:0]       local_armed,
    input logic                       err_flag,
    input logic                       irq
);
    localparam int GW = (NUM_REGS - NUM_LOCAL) * DATA_W;

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reload_evt |=> $stable(active_o));

    p_gre_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gre_armed && reload_evt && !gre_set) |=> !gre_armed);

    p_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!gre_armed && reload_evt) |=> ($stable(active_o[GW-1:0]) && err_flag));

    p_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !err_flag |-> !irq);

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);

    p_arm_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gre_set |=> gre_armed);

    generate
        for (genvar k = 0; k < NUM_LOCAL; k++) begin : g_lc
            p_local_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (local_armed[k] && reload_evt && !local_set[k]) |=> !local_armed[k]);
        end
    endgenerate
endmodule

bind shadow_reload_ctrl srr_checker #(
    .NUM_REGS(NUM_REGS), .NUM_LOCAL(NUM_LOCAL), .DATA_W(DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gre_set    (gre_set),
    .local_set  (local_set),
    .reload_evt (reload_evt),
    .err_clr    (err_clr),
    .active_o   (active_o),
    .gre_armed  (gre_armed),
    .local_armed(local_armed),
    .err_flag   (err_flag),
    .irq        (irq)
);

// File: tb/shadow_reload_ctrl_bench.sv
module shadow_reload_ctrl_bench;
    localparam int NR = 5;
    localparam int NL = 2;
    localparam int NG = NR - NL;
    localparam int DW = 16;
    localparam int AW = 3;
    localparam logic [DW-1:0] RV = 16'h00A5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic gre_set = 1'b0;
    logic [NL-1:0] local_set = '0;
    logic reload_evt = 1'b0;
    logic err_clr = 1'b0;
    logic err_irq_en = 1'b0;
    logic [NR*DW-1:0] active_o;
    logic gre_armed;
    logic [NL-1:0] local_armed;
    logic err_flag;
    logic irq;

    always #2.5 clk = ~clk;

    shadow_reload_ctrl #(
        .NUM_REGS(NR), .NUM_LOCAL(NL), .DATA_W(DW), .RST_VAL(RV), .ADDR_W(AW)
    ) u_shadow_reload_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .gre_set(gre_set), .local_set(local_set),
        .reload_evt(reload_evt), .err_clr(err_clr), .err_irq_en(err_irq_en),
        .active_o(active_o), .gre_armed(gre_armed), .local_armed(local_armed),
        .err_flag(err_flag), .irq(irq)
    );

    typedef struct {
        logic [NR*DW-1:0] act;
        logic             gre;
        logic [NL-1:0]    la;
        logic             err;
        logic             irq;
        string            tag;
    } exp_t;

    exp_t q[$];
    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    // reference model state
    logic [DW-1:0] sh_m [NR];
    logic [DW-1:0] ac_m [NR];
    logic          gre_m;
    logic [NL-1:0] la_m;
    logic          err_m;
    logic          ie_m;

    function automatic logic [NR*DW-1:0] flat();
        logic [NR*DW-1:0] v;
        for (int r = 0; r < NR; r++) v[r*DW +: DW] = ac_m[r];
        return v;
    endfunction

    task automatic push_exp(input string tag);
        exp_t e;
        e.act = flat();
        e.gre = gre_m;
        e.la  = la_m;
        e.err = err_m;
        e.irq = err_m & ie_m;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic step(input bit we, input int addr, input logic [DW-1:0] d,
                        input bit gs, input logic [NL-1:0] ls, input bit ev,
                        input bit ec, input bit ie, input string tag);
        bit commit, early;
        @(negedge clk);
        wr_en = we; wr_addr = AW'(addr); wr_data = d; gre_set = gs;
        local_set = ls; reload_evt = ev; err_clr = ec; err_irq_en = ie;
        commit = ev && gre_m;
        early  = ev && !gre_m;
        for (int r = 0; r < NG; r++) if (commit) ac_m[r] = sh_m[r];
        for (int k = 0; k < NL; k++) begin
            if (ev && la_m[k]) begin
                ac_m[NG+k] = sh_m[NG+k];
                la_m[k] = 1'b0;
            end
            if (ls[k]) la_m[k] = 1'b1;
        end
        if (ev) gre_m = 1'b0;
        if (gs) gre_m = 1'b1;
        if (ec) err_m = 1'b0;
        if (early) err_m = 1'b1;
        if (we && addr < NR) sh_m[addr] = d;
        ie_m = ie;
        @(posedge clk);
        #1;
        push_exp(tag);
    endtask

    task automatic chk(input string tag, input string what,
                       input logic [NR*DW-1:0] act, input logic [NR*DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // monitor: compares outputs after each edge against queued expectations
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(e.tag, "active_o", active_o, e.act);
                chk(e.tag, "gre_armed", {{(NR*DW-1){1'b0}}, gre_armed}, {{(NR*DW-1){1'b0}}, e.gre});
                chk(e.tag, "local_armed", {{(NR*DW-NL){1'b0}}, local_armed}, {{(NR*DW-NL){1'b0}}, e.la});
                chk(e.tag, "err_flag", {{(NR*DW-1){1'b0}}, err_flag}, {{(NR*DW-1){1'b0}}, e.err});
                chk(e.tag, "irq", {{(NR*DW-1){1'b0}}, irq}, {{(NR*DW-1){1'b0}}, e.irq});
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NR; r++) begin sh_m[r] = RV; ac_m[r] = RV; end
        gre_m = 1'b0; la_m = '0; err_m = 1'b0; ie_m = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        push_exp("R1 reset state");

        // R2: shadow writes without any event
        for (int r = 0; r < NR; r++)
            step(1, r, 16'h1000 + 16'(r), 0, '0, 0, 0, 0, "R2 shadow write hidden");
        // R10: out-of-range address
        step(1, 6, 16'hDEAD, 0, '0, 0, 0, 0, "R10 bad address");
        // R4: early event, error set, R5 irq masked
        step(0, 0, '0, 0, '0, 1, 0, 0, "R4 early event holds");
        step(0, 0, '0, 0, '0, 0, 0, 1, "R5 irq enabled");
        step(0, 0, '0, 0, '0, 0, 0, 0, "R5 irq disabled");
        step(0, 0, '0, 0, '0, 0, 0, 1, "R6 sticky");
        step(0, 0, '0, 0, '0, 0, 1, 1, "R6 cleared");
        // R6: clear and early event together
        step(0, 0, '0, 0, '0, 1, 1, 1, "R6 set beats clear");
        step(0, 0, '0, 0, '0, 0, 1, 1, "R6 clear again");
        // R3: arm then commit; local regs unchanged (R8)
        step(0, 0, '0, 1, '0, 0, 0, 1, "R3 armed");
        step(0, 0, '0, 0, '0, 1, 0, 1, "R3 commit R8 local held");
        // R8: arm one local reg, event with global clear
        step(0, 0, '0, 0, 2'b01, 0, 0, 1, "R8 local armed");
        step(0, 0, '0, 0, '0, 1, 0, 1, "R8 local copy");
        step(0, 0, '0, 0, '0, 0, 1, 1, "R8 clear err");
        step(0, 0, '0, 1, 2'b10, 0, 0, 1, "R8 both armed");
        step(0, 0, '0, 0, '0, 1, 0, 1, "R8 local with commit");
        // R7: write during committing event
        step(1, 0, 16'h2222, 1, '0, 0, 0, 1, "R7 pre write");
        step(1, 0, 16'h3333, 0, '0, 1, 0, 1, "R7 write at event");
        step(0, 0, '0, 1, '0, 0, 0, 1, "R7 rearm");
        step(0, 0, '0, 0, '0, 1, 0, 1, "R7 late value lands");
        // R9: arm request coinciding with events
        step(0, 0, '0, 1, 2'b11, 1, 0, 1, "R9 arm at early event");
        step(1, 1, 16'h4444, 0, '0, 0, 0, 1, "R9 write");
        step(1, 4, 16'h5555, 1, 2'b10, 1, 1, 0, "R9 arm at commit");
        step(0, 0, '0, 0, '0, 1, 0, 0, "R9 second commit");
        step(1, 2, 16'h6666, 0, '0, 0, 0, 0, "R2 late write hidden");
        step(0, 0, '0, 0, '0, 0, 0, 0, "R2 idle");
        repeat (3) @(posedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule